// File: doc/BRIEF.md
# Command/Response FIFO Engine

This block carries one command and its response between a host register port and a command-processing backend. The host writes command bytes into a 64-byte request buffer through a data register and steers the exchange through a status register. Once the command is complete it starts the backend. The backend then writes its response into a 64-byte response buffer, and the host drains that buffer one byte at a time through the same data register.

The block works out when a command is complete from a big-endian 32-bit length field. That field sits at byte offsets 2 to 5 of the command, and the response carries its own length at the same offsets. The status word also holds a burst count. While a response is waiting, the count is the number of unread response bytes. Otherwise it is the free space left in the request buffer.

Register map: the status word is at byte addresses 0 to 3, and a read at address n returns the word shifted right by 8·n bits. The data register is at address 4. Control writes to the status word act on bits 7:0 and only at address 0. Read data is registered and appears in the cycle after the read strobe. When a read and a write are requested in the same cycle, the write wins and the read has no side effects.

Top module: `cmd_resp_fifo`

## Requirements
- R1: After reset the engine is idle with status bits 7:0 all zero and a burst count of 64, so a status read returns 0x00004000, and a data read returns 0xFF.
- R2: Status bit positions are valid = 7, command-ready = 6, go = 5, data-available = 4, expect = 3 and retry = 1, with the burst count in bits 23:8. Writing 0x40 to the status register while idle enters the ready phase and sets only command-ready.
- R3: Writing command-ready in the ready phase only clears both byte pointers. In the completion phase it clears both pointers, enters ready, sets command-ready and clears data-available, so the status reads 0x00004040.
- R4: The first data byte written in ready enters the reception phase with status 0x88. Data bytes written while idle, executing or in completion are discarded, which leaves the burst count unchanged.
- R5: Once more than 5 command bytes are held, expect stays set while the big-endian length at offsets 2 to 5 exceeds the byte count. Expect clears, leaving status 0x80, when the command is complete. Bytes written while expect is clear are not stored.
- R6: A byte written when the request buffer already holds 64 bytes clears expect and leaves only valid set.
- R7: Writing 0x20 (go) is acted on only in reception with expect clear. The engine then enters execution and pulses the backend request for one cycle, with the request length equal to the stored byte count. The backend can read each stored byte by index. Go in any other case is ignored.
- R8: A response-done pulse during execution enters completion with status 0x90, both pointers at zero and the burst count equal to the response length. A response-done pulse in any other phase is ignored.
- R9: A data read in completion with data-available set returns the next response byte in order. Reading the last byte (the length at offsets 2 to 5, limited to 64) clears data-available and leaves valid set. Any other data read returns 0xFF.
- R10: The burst count is the unread response bytes while data-available is set and the free request space otherwise. A single-byte status access caps it at 0xFF.
- R11: Writing 0x02 (retry) in completion rewinds the response read pointer and restores status 0x90.
- R12: Writing command-ready during reception or execution aborts the command. The engine returns to ready with status 0x40 and empty buffers, and a one-cycle abort pulse goes to the backend when execution was aborted.
- R13: A status write with more than one of command-ready, go or retry set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Byte address: 0-3 status word, 4 data register |
| regByteAcc | input | 1 | Marks a single-byte access |
| regWrData | input | 32 | Write data (control and data bytes in bits 7:0) |
| regRdData | output | 32 | Read data, registered, valid the cycle after regRdEn |
| beReq | output | 1 | One-cycle pulse asking the backend to run the command |
| beReqLen | output | 7 | Number of command bytes held |
| beAbort | output | 1 | One-cycle pulse cancelling a running command |
| beCmdIdx | input | 6 | Backend index into the request buffer |
| beCmdByte | output | 8 | Request byte at beCmdIdx |
| beRspWr | input | 1 | Backend response byte write strobe (accepted while executing) |
| beRspIdx | input | 6 | Response byte index |
| beRspByte | input | 8 | Response byte value |
| beRspDone | input | 1 | Response complete pulse |

## Verification
Every control effect is registered at the clock edge that takes the write or pulse, so status and phase are due one cycle after the stimulus. Register read data is due in the cycle after the read strobe. The backend request and abort pulses are high for exactly the cycle after the go or abort write. The bench drives inputs on the falling edge and samples on the next falling edge, after that single register stage. It also checks that each pulse falls again one cycle later. Discarded bytes and ignored writes are checked through the burst count and the status bits read back straight afterwards.

// File: rtl/crf_pkg.sv
package crf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READY,
    PH_RECV,
    PH_EXEC,
    PH_COMPL
  } phase_t;

  localparam int STS_VALID  = 7;
  localparam int STS_CMDRDY = 6;
  localparam int STS_GO     = 5;
  localparam int STS_DAVAIL = 4;
  localparam int STS_EXPECT = 3;
  localparam int STS_RETRY  = 1;

  localparam logic [7:0] STS_CTRL_MASK = 8'h62;
  localparam logic [2:0] ADDR_DATA     = 3'd4;
  localparam int         LEN_LAST_OFS  = 5;

  typedef struct packed {
    logic clrPtrs;
    logic storeByte;
    logic rdAdvance;
    logic rewindRd;
  } dp_strobe_t;

endpackage

// File: rtl/crf_ctrl.sv
module crf_ctrl
  import crf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrByte,
  input  logic       beRspDone,
  input  logic       cmdFull,
  input  logic       needMore,
  input  logic       rspLast,
  output phase_t     phase,
  output logic [7:0] sts,
  output dp_strobe_t strobe,
  output logic       beReq,
  output logic       beAbort
);

  phase_t     phaseNext;
  logic [7:0] stsNext;
  logic       reqNext;
  logic       abortNext;

  logic       wrData;
  logic       wrSts;
  logic       rdData;
  logic [7:0] ctrlBits;
  logic       isCmdRdy;
  logic       isGo;
  logic       isRetry;
  logic       stsWrBad;
  logic       expectNow;
  logic       rspTaken;

  assign wrData   = regWrEn && (regAddr == ADDR_DATA);
  assign wrSts    = regWrEn && (regAddr == 3'd0);
  assign rdData   = regRdEn && !regWrEn && (regAddr == ADDR_DATA);
  assign ctrlBits = regWrByte & STS_CTRL_MASK;
  assign isCmdRdy = ctrlBits == (8'h1 << STS_CMDRDY);
  assign isGo     = ctrlBits == (8'h1 << STS_GO);
  assign isRetry  = ctrlBits == (8'h1 << STS_RETRY);
  assign stsWrBad = wrSts && !isCmdRdy && !isGo && !isRetry;
  assign rspTaken = beRspDone && (phase == PH_EXEC);

  always_comb begin
    phaseNext = phase;
    stsNext   = sts;
    strobe    = '0;
    reqNext   = 1'b0;
    abortNext = 1'b0;
    expectNow = 1'b0;
    if (rspTaken) begin
      phaseNext              = PH_COMPL;
      stsNext                = '0;
      stsNext[STS_VALID]     = 1'b1;
      stsNext[STS_DAVAIL]    = 1'b1;
      strobe.clrPtrs         = 1'b1;
    end else if (wrSts) begin
      if (isCmdRdy) begin
        strobe.clrPtrs = (phase != PH_IDLE);
        if (phase != PH_READY) begin
          phaseNext           = PH_READY;
          stsNext             = '0;
          stsNext[STS_CMDRDY] = 1'b1;
          abortNext           = (phase == PH_EXEC);
        end
      end else if (isGo) begin
        if (phase == PH_RECV && !sts[STS_EXPECT]) begin
          phaseNext = PH_EXEC;
          reqNext   = 1'b1;
        end
      end else if (isRetry) begin
        if (phase == PH_COMPL) begin
          strobe.rewindRd     = 1'b1;
          stsNext             = '0;
          stsNext[STS_VALID]  = 1'b1;
          stsNext[STS_DAVAIL] = 1'b1;
        end
      end
    end else if (wrData && (phase == PH_READY || phase == PH_RECV)) begin
      expectNow = (phase == PH_READY) ? 1'b1 : sts[STS_EXPECT];
      if (phase == PH_READY) begin
        phaseNext = PH_RECV;
      end
      if (expectNow) begin
        stsNext            = '0;
        stsNext[STS_VALID] = 1'b1;
        if (!cmdFull) begin
          strobe.storeByte    = 1'b1;
          stsNext[STS_EXPECT] = needMore;
        end
      end
    end else if (rdData && phase == PH_COMPL && sts[STS_DAVAIL]) begin
      strobe.rdAdvance = 1'b1;
      if (rspLast) begin
        stsNext            = '0;
        stsNext[STS_VALID] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      sts     <= '0;
      beReq   <= 1'b0;
      beAbort <= 1'b0;
    end else begin
      phase   <= phaseNext;
      sts     <= stsNext;
      beReq   <= reqNext;
      beAbort <= abortNext;
    end
  end

  // R1: idle always carries an empty status byte
  a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> (sts == 8'h00));

  // R5: expect only exists while a command is being received
  a_r5_expect_recv: assert property (@(posedge clk) disable iff (!rstN)
    sts[STS_EXPECT] |-> (phase == PH_RECV));

  // R7: a backend request pulse coincides with the execution phase
  a_r7_req_exec: assert property (@(posedge clk) disable iff (!rstN)
    beReq |-> (phase == PH_EXEC));

  // R7: the request is a single-cycle pulse
  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    beReq |=> !beReq);

  // R8: completion always reports valid status
  a_r8_compl_valid: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COMPL) |-> sts[STS_VALID]);

  // R9: data-available is only seen in completion
  a_r9_davail_compl: assert property (@(posedge clk) disable iff (!rstN)
    sts[STS_DAVAIL] |-> (phase == PH_COMPL));

  // R12: an abort pulse leaves the engine ready
  a_r12_abort_ready: assert property (@(posedge clk) disable iff (!rstN)
    beAbort |-> (phase == PH_READY));

  // R13: a malformed control write leaves the phase alone
  a_r13_bad_write: assert property (@(posedge clk) disable iff (!rstN)
    (stsWrBad && !beRspDone) |=> (phase == $past(phase)));

endmodule

// File: rtl/crf_datapath.sv
module crf_datapath
  import crf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_strobe_t    strobe,
  input  phase_t        phase,
  input  logic [7:0]    sts,
  input  logic          regRdEn,
  input  logic          regWrEn,
  input  logic [2:0]    regAddr,
  input  logic          regByteAcc,
  input  logic [7:0]    regWrByte,
  input  logic [IW-1:0] beCmdIdx,
  input  logic          beRspWr,
  input  logic [IW-1:0] beRspIdx,
  input  logic [7:0]    beRspByte,
  output logic          cmdFull,
  output logic          needMore,
  output logic          rspLast,
  output logic [PW-1:0] wrCount,
  output logic [7:0]    beCmdByte,
  output logic [31:0]   regRdData
);

  logic [7:0]    cmdBuf [DEPTH];
  logic [7:0]    rspBuf [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [PW-1:0] wrNext;
  logic [7:0]    lenByte [4];
  logic [31:0]   cmdLenAfter;
  logic [31:0]   rspLenRaw;
  logic [PW-1:0] rspLenEff;
  logic [15:0]   avail;
  logic [15:0]   burst;
  logic [31:0]   stsWord;
  logic [31:0]   rdWord;

  // length bytes as they will be once the incoming byte is stored
  for (genvar k = 0; k < 4; k++) begin : g_len
    localparam int OFS = LEN_LAST_OFS - 3 + k;
    assign lenByte[k] = (wrPtr == PW'(OFS)) ? regWrByte : cmdBuf[OFS];
  end

  assign wrNext      = wrPtr + PW'(1);
  assign cmdFull     = wrPtr == PW'(DEPTH);
  assign cmdLenAfter = {lenByte[0], lenByte[1], lenByte[2], lenByte[3]};
  assign needMore    = (wrNext <= PW'(LEN_LAST_OFS)) || (cmdLenAfter > 32'(wrNext));

  assign rspLenRaw = {rspBuf[LEN_LAST_OFS-3], rspBuf[LEN_LAST_OFS-2],
                      rspBuf[LEN_LAST_OFS-1], rspBuf[LEN_LAST_OFS]};
  assign rspLenEff = (rspLenRaw > 32'(DEPTH)) ? PW'(DEPTH) : rspLenRaw[PW-1:0];
  assign rspLast   = (rdPtr + PW'(1)) >= rspLenEff;

  assign wrCount   = wrPtr;
  assign beCmdByte = cmdBuf[beCmdIdx];

  always_comb begin
    if (sts[STS_DAVAIL]) avail = 16'(rspLenEff - rdPtr);
    else                 avail = 16'(PW'(DEPTH) - wrPtr);
    burst   = (regByteAcc && avail > 16'd255) ? 16'd255 : avail;
    stsWord = {8'h00, burst, sts};
    if (regAddr == ADDR_DATA) begin
      if (phase == PH_COMPL && sts[STS_DAVAIL]) rdWord = {24'h0, rspBuf[rdPtr[IW-1:0]]};
      else                                      rdWord = 32'h0000_00FF;
    end else begin
      rdWord = stsWord >> {regAddr[1:0], 3'b000};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      regRdData <= '0;
    end else begin
      if (strobe.clrPtrs) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (strobe.storeByte) wrPtr <= wrNext;
        if (strobe.rdAdvance) rdPtr <= rdPtr + PW'(1);
        if (strobe.rewindRd)  rdPtr <= '0;
      end
      if (regRdEn && !regWrEn) regRdData <= rdWord;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeByte) cmdBuf[wrPtr[IW-1:0]] <= regWrByte;
    if (beRspWr && phase == PH_EXEC) rspBuf[beRspIdx] <= beRspByte;
  end

  // R6: the write pointer never passes the buffer size
  a_r6_wr_bound: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= PW'(DEPTH));

  // R6: storing is never requested into a full buffer
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |-> !cmdFull);

  // R9: the read pointer never passes the buffer size
  a_r9_rd_bound: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= PW'(DEPTH));

endmodule

// File: rtl/cmd_resp_fifo.sv
module cmd_resp_fifo
  import crf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [2:0]    regAddr,
  input  logic          regByteAcc,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  output logic          beReq,
  output logic [PW-1:0] beReqLen,
  output logic          beAbort,
  input  logic [IW-1:0] beCmdIdx,
  output logic [7:0]    beCmdByte,
  input  logic          beRspWr,
  input  logic [IW-1:0] beRspIdx,
  input  logic [7:0]    beRspByte,
  input  logic          beRspDone
);

  phase_t     phase;
  logic [7:0] sts;
  dp_strobe_t strobe;
  logic       cmdFull;
  logic       needMore;
  logic       rspLast;

  crf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrByte (regWrData[7:0]),
    .beRspDone (beRspDone),
    .cmdFull   (cmdFull),
    .needMore  (needMore),
    .rspLast   (rspLast),
    .phase     (phase),
    .sts       (sts),
    .strobe    (strobe),
    .beReq     (beReq),
    .beAbort   (beAbort)
  );

  crf_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .phase      (phase),
    .sts        (sts),
    .regRdEn    (regRdEn),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regByteAcc (regByteAcc),
    .regWrByte  (regWrData[7:0]),
    .beCmdIdx   (beCmdIdx),
    .beRspWr    (beRspWr),
    .beRspIdx   (beRspIdx),
    .beRspByte  (beRspByte),
    .cmdFull    (cmdFull),
    .needMore   (needMore),
    .rspLast    (rspLast),
    .wrCount    (beReqLen),
    .beCmdByte  (beCmdByte),
    .regRdData  (regRdData)
  );

endmodule

// File: tb/cmd_resp_fifo_bench.sv
module cmd_resp_fifo_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regByteAcc = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        beReq;
  logic [6:0]  beReqLen;
  logic        beAbort;
  logic [5:0]  beCmdIdx = '0;
  logic [7:0]  beCmdByte;
  logic        beRspWr = 1'b0;
  logic [5:0]  beRspIdx = '0;
  logic [7:0]  beRspByte = '0;
  logic        beRspDone = 1'b0;

  int nChk = 0;
  int nErr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmd_resp_fifo u_cmd_resp_fifo (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regByteAcc(regByteAcc), .regWrData(regWrData),
    .regRdData(regRdData), .beReq(beReq), .beReqLen(beReqLen),
    .beAbort(beAbort), .beCmdIdx(beCmdIdx), .beCmdByte(beCmdByte),
    .beRspWr(beRspWr), .beRspIdx(beRspIdx), .beRspByte(beRspByte),
    .beRspDone(beRspDone)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmdByte(int i, int len);
    if (i >= 2 && i <= 5) return 8'(len >> (8 * (5 - i)));
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [7:0] rspByte(int i, int len);
    if (i >= 2 && i <= 5) return 8'(len >> (8 * (5 - i)));
    return 8'(8'hA0 + i);
  endfunction

  task automatic regWr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(logic [2:0] a, logic byteAcc, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a; regByteAcc = byteAcc;
    @(negedge clk);
    regRdEn = 1'b0; regByteAcc = 1'b0;
    d = regRdData;
  endtask

  task automatic stsIs(string req, logic [31:0] exp);
    logic [31:0] v;
    regRd(3'd0, 1'b0, v);
    chk(req, v, exp);
  endtask

  task automatic sendBytes(int first, int last, int len);
    for (int i = first; i <= last; i++) regWr(3'd4, 32'(cmdByte(i, len)));
  endtask

  task automatic respond(int len);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      beRspWr = 1'b1; beRspIdx = 6'(i); beRspByte = rspByte(i, len);
    end
    @(negedge clk);
    beRspWr = 1'b0; beRspDone = 1'b1;
    @(negedge clk);
    beRspDone = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    stsIs("R1 reset status", 32'h0000_4000);
    regRd(3'd4, 1'b0, v);
    chk("R1 reset data read", v, 32'hFF);
    regWr(3'd4, 32'h55);
    stsIs("R4 byte dropped in idle", 32'h0000_4000);
    regWr(3'd0, 32'h40);
    stsIs("R2 command-ready from idle", 32'h0000_4040);
  endtask

  task automatic t_command;
    sendBytes(0, 0, 10);
    stsIs("R4 first byte enters reception", 32'h0000_3F88);
    sendBytes(1, 8, 10);
    stsIs("R5 expect held while short", 32'h0000_3788);
    regWr(3'd0, 32'h20);
    chk("R7 go ignored with expect set", beReq, 0);
    stsIs("R7 status after ignored go", 32'h0000_3788);
    sendBytes(9, 9, 10);
    stsIs("R5 expect clears at length", 32'h0000_3680);
    regWr(3'd4, 32'h77);
    stsIs("R5 byte after complete not stored", 32'h0000_3680);
    regWr(3'd0, 32'h20);
    chk("R7 go raises request", beReq, 1);
    chk("R7 request length", 32'(beReqLen), 10);
    @(negedge clk);
    chk("R7 request is one pulse", beReq, 0);
    regWr(3'd4, 32'h99);
    stsIs("R4 byte dropped in execution", 32'h0000_3680);
    beCmdIdx = 6'd9;
    #1;
    chk("R7 backend reads command byte", beCmdByte, cmdByte(9, 10));
    beCmdIdx = 6'd3;
    #1;
    chk("R7 backend reads length byte", beCmdByte, 8'h00);
  endtask

  task automatic t_response;
    logic [31:0] v;
    respond(8);
    stsIs("R8 completion status", 32'h0000_0890);
    regWr(3'd4, 32'h11);
    stsIs("R4 byte dropped in completion", 32'h0000_0890);
    for (int i = 0; i < 7; i++) begin
      regRd(3'd4, 1'b0, v);
      chk("R9 response byte", v, 32'(rspByte(i, 8)));
    end
    stsIs("R10 burst counts unread bytes", 32'h0000_0190);
    regRd(3'd4, 1'b0, v);
    chk("R9 last response byte", v, 32'(rspByte(7, 8)));
    stsIs("R9 last read clears data-available", 32'h0000_4080);
    regRd(3'd4, 1'b0, v);
    chk("R9 read past end", v, 32'hFF);
    regRd(3'd1, 1'b1, v);
    chk("R10 byte lane 1 burst", v, 32'h40);
    regWr(3'd0, 32'h02);
    stsIs("R11 retry restores status", 32'h0000_0890);
    regRd(3'd4, 1'b0, v);
    chk("R11 retry rewinds", v, 32'(rspByte(0, 8)));
    regWr(3'd0, 32'h42);
    stsIs("R13 two-bit write ignored", 32'h0000_0790);
    regWr(3'd0, 32'h40);
    stsIs("R3 command-ready from completion", 32'h0000_4040);
    regWr(3'd0, 32'h40);
    stsIs("R3 command-ready in ready", 32'h0000_4040);
  endtask

  task automatic t_abort;
    sendBytes(0, 2, 6);
    stsIs("R4 partial command", 32'h0000_3D88);
    regWr(3'd0, 32'h40);
    chk("R12 no abort pulse from reception", beAbort, 0);
    stsIs("R12 abort from reception", 32'h0000_4040);
    sendBytes(0, 5, 6);
    stsIs("R5 length met at sixth byte", 32'h0000_3A80);
    regWr(3'd0, 32'h20);
    chk("R7 go after short command", beReqLen, 6);
    regWr(3'd0, 32'h40);
    chk("R12 abort pulse from execution", beAbort, 1);
    @(negedge clk);
    chk("R12 abort is one pulse", beAbort, 0);
    stsIs("R12 ready after abort", 32'h0000_4040);
    @(negedge clk); beRspDone = 1'b1;
    @(negedge clk); beRspDone = 1'b0;
    stsIs("R8 response done ignored in ready", 32'h0000_4040);
  endtask

  task automatic t_full;
    sendBytes(0, 63, 100);
    stsIs("R6 buffer full still expecting", 32'h0000_0088);
    regWr(3'd4, 32'hEE);
    stsIs("R6 overflow byte clears expect", 32'h0000_0080);
    regWr(3'd0, 32'h20);
    chk("R7 go with full buffer", 32'(beReqLen), 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_command();
    t_response();
    t_abort();
    t_full();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

endmodule